// File: doc/BRIEF.md
# Transmit Stream Framing Monitor

This block watches a packet-streaming transmit interface (valid, ready, start-of-packet marker, end-of-packet marker) without driving any of it. It only has inputs on the interface side. It checks the start and end markers of every beat against the framing rules. Each kind of violation raises a one-cycle pulse and a sticky flag. The sticky flags stay set until software or a debug controller pulses a synchronous clear.

A watchdog counts consecutive cycles with ready low. When that run grows longer than a configurable limit, the watchdog raises a stall indication. This is the usual symptom of a hung link, and the stall can serve as a trigger. A two-entry history records the start stamp, end stamp and an error bit for each of the last two closed packets. The stamps come from a free-running cycle counter. After a stall trigger, the framing that led up to the hang can be read straight from the history outputs.

Top module: `txs_frame_monitor`

## Requirements
- R1: A beat is transferred only in a cycle with tx_valid and tx_ready both high. Start or end markers seen with valid high but ready low do not change the framing state and raise no framing error.
- R2: A transferred start marker while a packet is already open raises error bit 0. That start then begins a fresh packet.
- R3: A transferred end marker without a start marker in the same beat, while no packet is open, raises error bit 1.
- R4: A start or end marker in a cycle with tx_valid low raises error bit 2 whatever tx_ready is. The open/closed state is left unchanged.
- R5: A transferred beat carrying both markers while no packet is open is a legal single-beat packet. It leaves no packet open.
- R6: stall_active is high once tx_ready has been low for more than STALL_LIMIT (default 100) consecutive cycles, counting from reset or from the last cycle with ready high. Error bit 3 pulses in the cycle stall_active rises.
- R7: The stall count saturates instead of wrapping, so stall_active stays high while ready stays low. Any cycle with ready high clears it from the next cycle on.
- R8: err_pulse shows a violation in the cycle after the offending cycle. err_sticky bits stay set until clr_i is high. A violation in the same cycle as clr_i still leaves its bit set.
- R9: Every transferred end marker pushes an entry into the history: entry 0 is the newest, the previous entry 0 moves to entry 1, and hist_valid bit 0 (newest) and bit 1 mark filled entries.
- R10: Stamps come from a cycle counter that is 0 in the first cycle after reset. An entry holds the stamp of its opening start beat and of its end beat, and both are the end-beat stamp for an orphan end. Its error bit is set if that packet saw R2 or is an R3 orphan.
- R11: After reset every flag, pulse, stall indication, open state and history output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of the sticky error flags |
| tx_valid | input | 1 | Observed beat valid |
| tx_ready | input | 1 | Observed sink ready |
| tx_sop | input | 1 | Observed start-of-packet marker |
| tx_eop | input | 1 | Observed end-of-packet marker |
| err_sticky | output | 4 | Sticky flags: bit0 duplicate start, bit1 orphan end, bit2 marker without valid, bit3 stall |
| err_pulse | output | 4 | One-cycle pulses, same bit order |
| stall_active | output | 1 | Ready has been low longer than STALL_LIMIT cycles |
| pkt_open | output | 1 | A packet has started and not yet ended |
| hist_valid | output | 2 | Filled history entries, bit0 newest |
| h0_sop_ts | output | TSW | Newest entry: start stamp |
| h0_eop_ts | output | TSW | Newest entry: end stamp |
| h0_err | output | 1 | Newest entry: framing error |
| h1_sop_ts | output | TSW | Older entry: start stamp |
| h1_eop_ts | output | TSW | Older entry: end stamp |
| h1_err | output | 1 | Older entry: framing error |

## Verification
The framing rules are tried with several kinds of packet:
- Multi-beat packets with ready dropping mid-packet and markers held through backpressure. These separate a transfer from a mere marker.
- Single-beat packets, which separate a legal start-and-end beat from a duplicate start.
- Doubled starts and orphan ends, which show whether each fault lands on its own bit and in the history error bit.
- Markers with valid low, which must flag bit 2 and leave the open state alone.

Ready-low runs of exactly the limit, one more than the limit, and far beyond it pin down the off-by-one edge and saturation. A clear that coincides with a new violation shows that setting a flag wins over clearing it.

// File: rtl/txs_mon_pkg.sv
package txs_mon_pkg;
  localparam int NERR           = 4;
  localparam int ERR_DUP_SOP    = 0;
  localparam int ERR_ORPHAN_EOP = 1;
  localparam int ERR_IDLE_MARK  = 2;
  localparam int ERR_STALL      = 3;
endpackage

// File: rtl/txs_frame_rules.sv
module txs_frame_rules #(
  parameter int TSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic           ready,
  input  logic           sop,
  input  logic           eop,
  input  logic [TSW-1:0] stamp,
  output logic           xfer,
  output logic           dup_ev,
  output logic           orphan_ev,
  output logic           idle_ev,
  output logic           open_o,
  output logic           close_ev,
  output logic [TSW-1:0] close_sop_ts,
  output logic           close_err
);
  logic           open_q;
  logic           perr_q;
  logic [TSW-1:0] sop_ts_q;

  function automatic logic [TSW-1:0] pick_start(input logic s, input logic op,
                                                 input logic [TSW-1:0] held,
                                                 input logic [TSW-1:0] now);
    if (s)       return now;
    else if (op) return held;
    else         return now;
  endfunction

  assign xfer         = valid & ready;
  assign dup_ev       = xfer & sop & open_q;
  assign orphan_ev    = xfer & eop & ~sop & ~open_q;
  assign idle_ev      = (sop | eop) & ~valid;
  assign close_ev     = xfer & eop;
  assign close_sop_ts = pick_start(sop, open_q, sop_ts_q, stamp);
  assign close_err    = dup_ev | orphan_ev | (open_q & ~sop & perr_q);
  assign open_o       = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      perr_q   <= 1'b0;
      sop_ts_q <= '0;
    end else if (xfer) begin
      if (sop) begin
        open_q   <= ~eop;
        perr_q   <= open_q;
        sop_ts_q <= stamp;
      end else if (eop) begin
        open_q <= 1'b0;
        perr_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txs_stall_wdog.sv
module txs_stall_wdog #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  output logic stall_o,
  output logic hit_ev
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] cnt_next(input logic rdy, input logic [CW-1:0] c);
    if (rdy)           return '0;
    else if (c == SAT) return SAT;
    else               return c + CW'(1);
  endfunction

  assign stall_o = (cnt_q == SAT);
  assign hit_ev  = ~ready & (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next(ready, cnt_q);
  end
endmodule

// File: rtl/txs_frame_history.sv
module txs_frame_history #(
  parameter int TSW   = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TSW-1:0]   sop_ts,
  input  logic [TSW-1:0]   eop_ts,
  input  logic             err,
  output logic [DEPTH-1:0] fill,
  output logic [TSW-1:0]   sop_o [DEPTH],
  output logic [TSW-1:0]   eop_o [DEPTH],
  output logic             err_o [DEPTH]
);
  typedef struct packed {
    logic [TSW-1:0] s;
    logic [TSW-1:0] e;
    logic           x;
  } ent_t;

  ent_t             ent_q [DEPTH];
  logic [DEPTH-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push) begin
      fill_q <= {fill_q[DEPTH-2:0], 1'b1};
      ent_q[0] <= '{s: sop_ts, e: eop_ts, x: err};
      for (int i = 1; i < DEPTH; i++) ent_q[i] <= ent_q[i-1];
    end
  end

  assign fill = fill_q;
  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign sop_o[g] = ent_q[g].s;
    assign eop_o[g] = ent_q[g].e;
    assign err_o[g] = ent_q[g].x;
  end
endmodule

// File: rtl/txs_err_flags.sv
module txs_err_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] ev,
  output logic [N-1:0] sticky,
  output logic [N-1:0] pulse
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic st_q, pl_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= 1'b0;
        pl_q <= 1'b0;
      end else begin
        st_q <= (st_q & ~clr) | ev[g];
        pl_q <= ev[g];
      end
    end
    assign sticky[g] = st_q;
    assign pulse[g]  = pl_q;
  end
endmodule

// File: rtl/txs_frame_monitor.sv
module txs_frame_monitor
  import txs_mon_pkg::*;
#(
  parameter int STALL_LIMIT = 100,
  parameter int TSW         = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            tx_valid,
  input  logic            tx_ready,
  input  logic            tx_sop,
  input  logic            tx_eop,
  output logic [NERR-1:0] err_sticky,
  output logic [NERR-1:0] err_pulse,
  output logic            stall_active,
  output logic            pkt_open,
  output logic [1:0]      hist_valid,
  output logic [TSW-1:0]  h0_sop_ts,
  output logic [TSW-1:0]  h0_eop_ts,
  output logic            h0_err,
  output logic [TSW-1:0]  h1_sop_ts,
  output logic [TSW-1:0]  h1_eop_ts,
  output logic            h1_err
);
  logic [TSW-1:0] cyc_now;
  logic           xfer_beat, dup_sop_ev, orphan_eop_ev, idle_mark_ev, stall_hit_ev;
  logic           close_ev, close_err;
  logic [TSW-1:0] close_sop_ts;
  logic [NERR-1:0] ev_vec;
  logic [TSW-1:0] hs [2];
  logic [TSW-1:0] he [2];
  logic           hx [2];

  function automatic logic [TSW-1:0] stamp_step(input logic [TSW-1:0] t);
    return t + TSW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_now <= '0;
    else        cyc_now <= stamp_step(cyc_now);
  end

  txs_frame_rules #(.TSW(TSW)) u_rules (
    .clk(clk), .rst_n(rst_n), .valid(tx_valid), .ready(tx_ready),
    .sop(tx_sop), .eop(tx_eop), .stamp(cyc_now),
    .xfer(xfer_beat), .dup_ev(dup_sop_ev), .orphan_ev(orphan_eop_ev),
    .idle_ev(idle_mark_ev), .open_o(pkt_open), .close_ev(close_ev),
    .close_sop_ts(close_sop_ts), .close_err(close_err)
  );

  txs_stall_wdog #(.LIMIT(STALL_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .ready(tx_ready),
    .stall_o(stall_active), .hit_ev(stall_hit_ev)
  );

  always_comb begin
    ev_vec                 = '0;
    ev_vec[ERR_DUP_SOP]    = dup_sop_ev;
    ev_vec[ERR_ORPHAN_EOP] = orphan_eop_ev;
    ev_vec[ERR_IDLE_MARK]  = idle_mark_ev;
    ev_vec[ERR_STALL]      = stall_hit_ev;
  end

  txs_err_flags #(.N(NERR)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .ev(ev_vec),
    .sticky(err_sticky), .pulse(err_pulse)
  );

  txs_frame_history #(.TSW(TSW), .DEPTH(2)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(close_ev),
    .sop_ts(close_sop_ts), .eop_ts(cyc_now), .err(close_err),
    .fill(hist_valid), .sop_o(hs), .eop_o(he), .err_o(hx)
  );

  assign h0_sop_ts = hs[0];
  assign h0_eop_ts = he[0];
  assign h0_err    = hx[0];
  assign h1_sop_ts = hs[1];
  assign h1_eop_ts = he[1];
  assign h1_err    = hx[1];
endmodule

// File: rtl/txs_frame_monitor_chk.sv
module txs_frame_monitor_chk
  import txs_mon_pkg::*;
#(
  parameter int TSW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_i,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            tx_sop,
  input logic            tx_eop,
  input logic            xfer_beat,
  input logic [TSW-1:0]  cyc_now,
  input logic [NERR-1:0] err_sticky,
  input logic [NERR-1:0] err_pulse,
  input logic            stall_active,
  input logic            pkt_open,
  input logic [1:0]      hist_valid,
  input logic [TSW-1:0]  h0_eop_ts
);
  a_r2_dup_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_sop && pkt_open) |=> err_pulse[ERR_DUP_SOP]);

  a_r3_orphan_end: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop && !tx_sop && !pkt_open) |=> err_pulse[ERR_ORPHAN_EOP]);

  a_r4_idle_marker: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_sop || tx_eop) && !tx_valid) |=> (err_pulse[ERR_IDLE_MARK] && $stable(pkt_open)));

  a_r5_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_beat && tx_sop && tx_eop) |=> !pkt_open);

  a_r6_stall_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[ERR_STALL] |-> (stall_active && !$past(stall_active)));

  a_r7_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !stall_active);

  a_r7_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_active && !tx_ready) |=> stall_active);

  a_r8_pulse_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_pulse & ~err_sticky) == '0));

  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  a_r9_history_push: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_beat && tx_eop) |=> (hist_valid[0] && h0_eop_ts == $past(cyc_now)));
endmodule

bind txs_frame_monitor txs_frame_monitor_chk #(.TSW(TSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
  .xfer_beat(xfer_beat), .cyc_now(cyc_now), .err_sticky(err_sticky),
  .err_pulse(err_pulse), .stall_active(stall_active), .pkt_open(pkt_open),
  .hist_valid(hist_valid), .h0_eop_ts(h0_eop_ts)
);

// File: tb/txs_frame_monitor_bench.sv
module txs_frame_monitor_bench;
  localparam int LIMIT = 100;
  localparam int TW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0, tx_valid = 1'b0, tx_ready = 1'b1, tx_sop = 1'b0, tx_eop = 1'b0;
  logic [3:0] err_sticky, err_pulse;
  logic stall_active, pkt_open, h0_err, h1_err;
  logic [1:0] hist_valid;
  logic [TW-1:0] h0_sop_ts, h0_eop_ts, h1_sop_ts, h1_eop_ts;

  always #4 clk = ~clk;

  txs_frame_monitor u_txs_frame_monitor (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .err_sticky(err_sticky), .err_pulse(err_pulse), .stall_active(stall_active),
    .pkt_open(pkt_open), .hist_valid(hist_valid),
    .h0_sop_ts(h0_sop_ts), .h0_eop_ts(h0_eop_ts), .h0_err(h0_err),
    .h1_sop_ts(h1_sop_ts), .h1_eop_ts(h1_eop_ts), .h1_err(h1_err)
  );

  int checks = 0;
  int errors = 0;

  typedef struct { int s; int e; int x; } rec_t;
  rec_t hq[$];
  int tc = 0, lows = 0, m_open = 0, m_perr = 0, m_sopts = 0;
  int m_sticky[4], m_pulse[4];

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    tc = 0; lows = 0; m_open = 0; m_perr = 0; m_sopts = 0;
    hq.delete();
    for (int i = 0; i < 4; i++) begin m_sticky[i] = 0; m_pulse[i] = 0; end
  endtask

  task automatic model_update();
    int v, r, s, e, xf, ev[4];
    rec_t n;
    v = tx_valid; r = tx_ready; s = tx_sop; e = tx_eop;
    xf = v & r;
    ev[0] = xf & s & m_open;
    ev[1] = xf & e & (s == 0) & (m_open == 0);
    ev[2] = (s | e) & (v == 0);
    ev[3] = (r == 0 && lows == LIMIT) ? 1 : 0;
    if (xf && e) begin
      n.e = tc;
      n.s = s ? tc : (m_open ? m_sopts : tc);
      n.x = (ev[0] || ev[1] || (m_open && !s && m_perr)) ? 1 : 0;
      hq.push_front(n);
      if (hq.size() > 2) void'(hq.pop_back());
    end
    if (xf && s) begin
      m_perr = m_open; m_open = e ? 0 : 1; m_sopts = tc;
    end else if (xf && e) begin
      m_open = 0; m_perr = 0;
    end
    if (r) lows = 0;
    else if (lows <= LIMIT) lows++;
    for (int i = 0; i < 4; i++) begin
      m_pulse[i]  = ev[i];
      m_sticky[i] = (clr_i ? 0 : m_sticky[i]) | ev[i];
    end
    tc = (tc + 1) % (1 << TW);
  endtask

  task automatic compare_all();
    string tags[4] = '{"R2", "R3", "R4", "R6"};
    for (int i = 0; i < 4; i++) begin
      chk(err_pulse[i], m_pulse[i], tags[i]);
      chk(err_sticky[i], m_sticky[i], "R8");
    end
    chk(stall_active, (lows > LIMIT) ? 1 : 0, "R6");
    chk(pkt_open, m_open, "R1");
    chk(hist_valid[0], (hq.size() > 0) ? 1 : 0, "R9");
    chk(hist_valid[1], (hq.size() > 1) ? 1 : 0, "R9");
    chk(h0_sop_ts, (hq.size() > 0) ? hq[0].s : 0, "R10");
    chk(h0_eop_ts, (hq.size() > 0) ? hq[0].e : 0, "R10");
    chk(h0_err,    (hq.size() > 0) ? hq[0].x : 0, "R10");
    chk(h1_sop_ts, (hq.size() > 1) ? hq[1].s : 0, "R9");
    chk(h1_eop_ts, (hq.size() > 1) ? hq[1].e : 0, "R9");
    chk(h1_err,    (hq.size() > 1) ? hq[1].x : 0, "R9");
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input logic v, input logic r, input logic s, input logic e, input logic c);
    tx_valid = v; tx_ready = r; tx_sop = s; tx_eop = e; clr_i = c;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: everything zero out of reset
    chk(err_sticky, 0, "R11"); chk(err_pulse, 0, "R11");
    chk(stall_active, 0, "R11"); chk(pkt_open, 0, "R11");
    chk(hist_valid, 0, "R11"); chk(h0_eop_ts, 0, "R11");
    idle(2);

    // R1: multi-beat packet, start held through backpressure
    drive(1, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    chk(pkt_open, 0, "R1");
    drive(1, 1, 1, 0, 0);
    drive(1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0);
    drive(1, 0, 0, 1, 0);
    chk(pkt_open, 1, "R1");
    drive(1, 1, 0, 1, 0);
    chk(err_sticky, 0, "R1");
    chk(h0_eop_ts - h0_sop_ts, 4, "R10");
    idle(2);

    // R5: single-beat packets back to back
    drive(1, 1, 1, 1, 0);
    drive(1, 1, 1, 1, 0);
    chk(pkt_open, 0, "R5");
    chk(err_sticky, 0, "R5");
    chk(h0_sop_ts, h0_eop_ts, "R5");
    idle(1);

    // R2: duplicate start
    drive(1, 1, 1, 0, 0);
    drive(1, 1, 1, 0, 0);
    chk(err_pulse[0], 1, "R2");
    drive(1, 1, 0, 1, 0);
    chk(h0_err, 1, "R10");
    idle(1);

    // R3: orphan end
    drive(1, 1, 0, 1, 0);
    chk(err_pulse[1], 1, "R3");
    chk(h0_sop_ts, h0_eop_ts, "R10");
    chk(h0_err, 1, "R10");
    idle(1);

    // R4: markers with valid low, inside and outside a packet
    drive(0, 1, 1, 0, 0);
    chk(err_pulse[2], 1, "R4");
    chk(pkt_open, 0, "R4");
    drive(1, 1, 1, 0, 0);
    drive(0, 0, 0, 1, 0);
    chk(pkt_open, 1, "R4");
    drive(1, 1, 0, 1, 0);
    chk(h0_err, 0, "R4");
    idle(1);

    // R8: clear, and clear colliding with a new violation
    drive(0, 1, 0, 0, 1);
    chk(err_sticky, 0, "R8");
    drive(1, 1, 0, 1, 1);
    chk(err_sticky, 4'b0010, "R8");
    drive(0, 1, 0, 0, 1);
    idle(2);

    // R6: exactly LIMIT low cycles is not a stall
    for (int i = 0; i < LIMIT; i++) drive(0, 0, 0, 0, 0);
    chk(stall_active, 0, "R6");
    idle(1);
    // R6: one more than LIMIT is a stall
    for (int i = 0; i < LIMIT + 1; i++) drive(0, 0, 0, 0, 0);
    chk(stall_active, 1, "R6");
    chk(err_pulse[3], 1, "R6");
    // R7: saturation over a long run, then ready clears
    for (int i = 0; i < 300; i++) drive(0, 0, 0, 0, 0);
    chk(stall_active, 1, "R7");
    chk(err_pulse[3], 0, "R7");
    drive(0, 1, 0, 0, 0);
    chk(stall_active, 0, "R7");
    idle(2);

    // R9: three packets, history keeps the last two
    drive(1, 1, 1, 1, 0);
    drive(1, 1, 1, 0, 0);
    drive(1, 1, 0, 1, 0);
    drive(1, 1, 1, 0, 0);
    drive(1, 1, 0, 0, 0);
    drive(1, 1, 0, 1, 0);
    chk(hist_valid, 2'b11, "R9");
    chk(h0_eop_ts - h1_eop_ts, 3, "R9");
    chk(h0_eop_ts - h0_sop_ts, 2, "R9");
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule